// File: doc/BRIEF.md
# PIO Cycle Count Calculator

This block turns one programmed-I/O transfer timing request into bus-clock counts for a disk interface timing unit. The caller supplies the address setup time, the strobe active time and the full cycle time in nanoseconds, the bus clock period in nanoseconds, and a small silicon revision code. It pulses `start` once. The block then works out the setup, active and recovery clock counts and also packs the active and recovery counts into one timing byte.

Every nanosecond-to-clock conversion is a ceiling division. All of these share one shift-subtract divider, which is used four times in turn. The counts then go through a fixed chain of clamps. The active count gets a floor. The recovery count is taken as the larger of two candidates, gets a floor, and any excess above 17 is moved into the active count. The active count then gets a ceiling. Last come a decrement that depends on the revision and a final recovery ceiling.

A controller FSM sequences the work through these states: `ST_IDLE`, `ST_SETUP`, `ST_ACTIVE`, `ST_CYCLE`, `ST_RECOV`, `ST_CLAMP` and `ST_DONE`. Its transitions are:
- `ST_IDLE` goes to `ST_SETUP` on a start with a non-zero period.
- `ST_IDLE` goes straight to `ST_DONE` on a start with a zero period.
- Each of the four divide states advances to the next one when the divider acknowledges. `ST_RECOV` advances to `ST_CLAMP`.
- `ST_CLAMP` goes to `ST_DONE` after one cycle.
- `ST_DONE` returns to `ST_IDLE` after one cycle.

Top module: `pio_cycle_calc`

## Requirements
- R1: Setup, active, cycle and recovery times are each converted to clocks as (time + period - 1) / period, using integer division.
- R2: The recovery time is the cycle time minus (setup time + active time), taken as 0 when negative. The recovery count is the larger of ceil(recovery time) and (cycle count - setup count - active count), where the second term is taken as 0 when negative.
- R3: An active count below 2 is raised to 2 before the second recovery candidate is formed.
- R4: A recovery count below 2 is raised to 2. A recovery count above 17 has its excess added to the active count and is itself set to 17.
- R5: After that transfer, the active count is limited to 16, so `active_clk` lies in 2..16 on every non-error result.
- R6: When `rev` > 1, one is subtracted from the recovery count. In every case the recovery count is then limited to 16.
- R7: `timing_byte` bits [7:4] hold active_clk[3:0] and bits [3:0] hold recovery_clk[3:0], so a count of 16 appears as nibble 0.
- R8: A `start` pulse in idle latches all inputs. Results appear with `done` high for exactly one cycle and are held until the next `done`.
- R9: A `start` asserted while `busy` is high is ignored. It changes no result and produces no extra `done`.
- R10: A start with `period_ns` = 0 performs no division. It gives `done` one cycle later with `err` = 1 and with `setup_clk`, `active_clk`, `recovery_clk` and `timing_byte` all zero.
- R11: After reset, `busy`, `done`, `err` and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted only while idle |
| setup_ns | input | TIME_W | Address setup time in ns |
| active_ns | input | TIME_W | Strobe active time in ns |
| cycle_ns | input | TIME_W | Full transfer cycle time in ns |
| period_ns | input | PER_W | Bus clock period in ns |
| rev | input | REV_W | Silicon revision code |
| busy | output | 1 | High from the cycle after an accepted start through the done cycle |
| done | output | 1 | One-cycle result-valid pulse |
| err | output | 1 | Last request had a zero period |
| setup_clk | output | TIME_W | Setup clock count |
| active_clk | output | 5 | Active clock count (2..16) |
| recovery_clk | output | 5 | Recovery clock count (1..16) |
| timing_byte | output | 8 | Packed active/recovery nibbles |

## Verification
The assertions take three things for granted:
- The divider is never launched with a zero divisor or while it is already running.
- The latched inputs stay fixed for the whole computation.
- `start` is a pulse that the caller may raise at any time.

The stimulus stays within these conditions. It pulses `start` for one cycle per request. Zero periods are sent only in the dedicated error test, where the FSM must bypass the divider. A second `start` is sent during a busy window only to show that it is ignored. Time values are kept small enough that the ceiling numerator fits one bit beyond the time width.

// File: rtl/pio_calc_pkg.sv
package pio_calc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACTIVE,
        ST_CYCLE,
        ST_RECOV,
        ST_CLAMP,
        ST_DONE
    } calc_state_e;

    localparam int CNT_OUT_W     = 5;
    localparam int ACT_FLOOR     = 2;
    localparam int REC_FLOOR     = 2;
    localparam int REC_SPILL_AT  = 17;
    localparam int CNT_CEIL      = 16;
    localparam int REV_DEC_ABOVE = 1;

    function automatic logic [7:0] pack_timing(
        input logic [CNT_OUT_W-1:0] act,
        input logic [CNT_OUT_W-1:0] rec
    );
        return {act[3:0], rec[3:0]};
    endfunction

endpackage

// File: rtl/pio_ceil_div.sv
module pio_ceil_div #(
    parameter int NUM_W = 12,
    parameter int DEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             busy,
    output logic             ack,
    output logic [NUM_W-1:0] quo
);
    localparam int EW    = NUM_W + 1;
    localparam int CNT_W = $clog2(EW + 1);
    localparam int PW    = NUM_W + DEN_W + 1;

    logic [EW-1:0]    q;
    logic [DEN_W-1:0] rem;
    logic [DEN_W-1:0] den_q;
    logic [NUM_W-1:0] num_q;
    logic [CNT_W-1:0] cnt;
    logic [DEN_W:0]   rem_sh;
    logic [DEN_W:0]   rem_sub;
    logic             take;

    assign rem_sh  = {rem, q[EW-1]};
    assign rem_sub = rem_sh - {1'b0, den_q};
    assign take    = (rem_sh >= {1'b0, den_q});
    assign busy    = (cnt != '0);
    assign quo     = q[NUM_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            rem   <= '0;
            den_q <= '0;
            num_q <= '0;
            cnt   <= '0;
            ack   <= 1'b0;
        end else begin
            ack <= 1'b0;
            if (go && !busy) begin
                q     <= EW'(num) + EW'(den) - EW'(1);
                rem   <= '0;
                den_q <= den;
                num_q <= num;
                cnt   <= CNT_W'(EW);
            end else if (busy) begin
                rem <= take ? rem_sub[DEN_W-1:0] : rem_sh[DEN_W-1:0];
                q   <= {q[EW-2:0], take};
                cnt <= cnt - CNT_W'(1);
                if (cnt == CNT_W'(1)) begin
                    ack <= 1'b1;
                end
            end
        end
    end

    logic [PW-1:0] prod_hi;
    logic [PW-1:0] prod_lo;
    assign prod_hi = PW'(quo) * PW'(den_q);
    assign prod_lo = prod_hi - PW'(den_q);

    // R1: quotient is the smallest multiple count covering the numerator
    assert_ceil_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (prod_hi >= PW'(num_q)) && ((num_q == '0) || (prod_lo < PW'(num_q))));

    // R10: a zero divisor never reaches the divider
    assert_den_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (den != '0));

    // R8: launches only arrive while idle
    assert_go_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !busy);

endmodule

// File: rtl/pio_count_clamp.sv
module pio_count_clamp
    import pio_calc_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int REV_W = 2
) (
    input  logic [CNT_W-1:0]     setup_cnt,
    input  logic [CNT_W-1:0]     active_raw,
    input  logic [CNT_W-1:0]     cycle_cnt,
    input  logic [CNT_W-1:0]     rectime_cnt,
    input  logic [REV_W-1:0]     rev,
    output logic [CNT_OUT_W-1:0] active_out,
    output logic [CNT_OUT_W-1:0] recovery_out
);
    localparam int IW = CNT_W + 2;

    logic [IW-1:0] act_floor;
    logic [IW-1:0] sum_sa;
    logic [IW-1:0] rec_from_cycle;
    logic [IW-1:0] rec_max;
    logic [IW-1:0] rec_floor;
    logic [IW-1:0] act_spill;
    logic [IW-1:0] rec_spill;
    logic [IW-1:0] act_ceil;
    logic [IW-1:0] rec_dec;
    logic [IW-1:0] rec_ceil;

    always_comb begin
        act_floor = (IW'(active_raw) < IW'(ACT_FLOOR)) ? IW'(ACT_FLOOR) : IW'(active_raw);

        sum_sa         = IW'(setup_cnt) + act_floor;
        rec_from_cycle = (IW'(cycle_cnt) >= sum_sa) ? (IW'(cycle_cnt) - sum_sa) : '0;
        rec_max        = (IW'(rectime_cnt) >= rec_from_cycle) ? IW'(rectime_cnt) : rec_from_cycle;

        rec_floor = (rec_max < IW'(REC_FLOOR)) ? IW'(REC_FLOOR) : rec_max;

        if (rec_floor > IW'(REC_SPILL_AT)) begin
            act_spill = act_floor + (rec_floor - IW'(REC_SPILL_AT));
            rec_spill = IW'(REC_SPILL_AT);
        end else begin
            act_spill = act_floor;
            rec_spill = rec_floor;
        end

        act_ceil = (act_spill > IW'(CNT_CEIL)) ? IW'(CNT_CEIL) : act_spill;

        rec_dec  = (int'(rev) > REV_DEC_ABOVE) ? (rec_spill - IW'(1)) : rec_spill;
        rec_ceil = (rec_dec > IW'(CNT_CEIL)) ? IW'(CNT_CEIL) : rec_dec;

        active_out   = act_ceil[CNT_OUT_W-1:0];
        recovery_out = rec_ceil[CNT_OUT_W-1:0];
    end

    // R4: after the spill the recovery count sits in its legal window
    always_comb begin
        assert_rec_window_R4: assert ((rec_spill >= IW'(REC_FLOOR)) && (rec_spill <= IW'(REC_SPILL_AT)));
    end

endmodule

// File: rtl/pio_cycle_calc.sv
module pio_cycle_calc
    import pio_calc_pkg::*;
#(
    parameter int TIME_W = 12,
    parameter int PER_W  = 8,
    parameter int REV_W  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [TIME_W-1:0]    setup_ns,
    input  logic [TIME_W-1:0]    active_ns,
    input  logic [TIME_W-1:0]    cycle_ns,
    input  logic [PER_W-1:0]     period_ns,
    input  logic [REV_W-1:0]     rev,
    output logic                 busy,
    output logic                 done,
    output logic                 err,
    output logic [TIME_W-1:0]    setup_clk,
    output logic [CNT_OUT_W-1:0] active_clk,
    output logic [CNT_OUT_W-1:0] recovery_clk,
    output logic [7:0]           timing_byte
);
    calc_state_e state, state_n;
    logic        launch_q;
    logic        enter_div;

    logic [TIME_W-1:0] lat_setup, lat_active, lat_cycle;
    logic [PER_W-1:0]  lat_per;
    logic [REV_W-1:0]  lat_rev;
    logic [TIME_W-1:0] cnt_s, cnt_a, cnt_c, cnt_r;

    logic [TIME_W:0]   sa_ns;
    logic [TIME_W:0]   rec_diff;
    logic [TIME_W-1:0] rec_ns;

    logic [TIME_W-1:0]    div_num;
    logic                 div_busy;
    logic                 div_ack;
    logic [TIME_W-1:0]    div_quo;
    logic [CNT_OUT_W-1:0] cl_act, cl_rec;

    // recovery time in ns, floored at zero
    assign sa_ns    = {1'b0, lat_setup} + {1'b0, lat_active};
    assign rec_diff = {1'b0, lat_cycle} - sa_ns;
    assign rec_ns   = ({1'b0, lat_cycle} >= sa_ns) ? rec_diff[TIME_W-1:0] : '0;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            launch_q <= 1'b0;
        end else begin
            state    <= state_n;
            launch_q <= enter_div;
        end
    end

    // next state and outputs
    always_comb begin
        state_n = state;
        div_num = '0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_n = (period_ns == '0) ? ST_DONE : ST_SETUP;
                end
            end
            ST_SETUP: begin
                div_num = lat_setup;
                if (div_ack) state_n = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                div_num = lat_active;
                if (div_ack) state_n = ST_CYCLE;
            end
            ST_CYCLE: begin
                div_num = lat_cycle;
                if (div_ack) state_n = ST_RECOV;
            end
            ST_RECOV: begin
                div_num = rec_ns;
                if (div_ack) state_n = ST_CLAMP;
            end
            ST_CLAMP: state_n = ST_DONE;
            ST_DONE:  state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
        enter_div = (state_n != state) &&
                    ((state_n == ST_SETUP) || (state_n == ST_ACTIVE) ||
                     (state_n == ST_CYCLE) || (state_n == ST_RECOV));
        busy = (state != ST_IDLE);
        done = (state == ST_DONE);
    end

    pio_ceil_div #(
        .NUM_W (TIME_W),
        .DEN_W (PER_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (launch_q),
        .num   (div_num),
        .den   (lat_per),
        .busy  (div_busy),
        .ack   (div_ack),
        .quo   (div_quo)
    );

    pio_count_clamp #(
        .CNT_W (TIME_W),
        .REV_W (REV_W)
    ) u_clamp (
        .setup_cnt    (cnt_s),
        .active_raw   (cnt_a),
        .cycle_cnt    (cnt_c),
        .rectime_cnt  (cnt_r),
        .rev          (lat_rev),
        .active_out   (cl_act),
        .recovery_out (cl_rec)
    );

    // datapath: latch, collect quotients, publish results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_setup    <= '0;
            lat_active   <= '0;
            lat_cycle    <= '0;
            lat_per      <= '0;
            lat_rev      <= '0;
            cnt_s        <= '0;
            cnt_a        <= '0;
            cnt_c        <= '0;
            cnt_r        <= '0;
            err          <= 1'b0;
            setup_clk    <= '0;
            active_clk   <= '0;
            recovery_clk <= '0;
            timing_byte  <= '0;
        end else begin
            if (state == ST_IDLE && start) begin
                lat_setup  <= setup_ns;
                lat_active <= active_ns;
                lat_cycle  <= cycle_ns;
                lat_per    <= period_ns;
                lat_rev    <= rev;
                err        <= (period_ns == '0);
                if (period_ns == '0) begin
                    setup_clk    <= '0;
                    active_clk   <= '0;
                    recovery_clk <= '0;
                    timing_byte  <= '0;
                end
            end
            if (div_ack) begin
                unique case (state)
                    ST_SETUP:  cnt_s <= div_quo;
                    ST_ACTIVE: cnt_a <= div_quo;
                    ST_CYCLE:  cnt_c <= div_quo;
                    ST_RECOV:  cnt_r <= div_quo;
                    default:   ;
                endcase
            end
            if (state == ST_CLAMP) begin
                setup_clk    <= cnt_s;
                active_clk   <= cl_act;
                recovery_clk <= cl_rec;
                timing_byte  <= pack_timing(cl_act, cl_rec);
            end
        end
    end

    // R8: done lasts one cycle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: divider is never busy while the FSM waits in idle
    assert_div_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !div_busy);

    // R9: start during busy leaves the captured request untouched
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(lat_per) && $stable(lat_cycle) && $stable(lat_rev)));

    // R10: error results are cleared
    assert_err_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (setup_clk == '0 && active_clk == '0 &&
                           recovery_clk == '0 && timing_byte == '0));

    // R5: active count window on good results
    assert_active_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (active_clk >= CNT_OUT_W'(ACT_FLOOR) && active_clk <= CNT_OUT_W'(CNT_CEIL)));

    // R6: recovery count window on good results
    assert_rec_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (recovery_clk >= CNT_OUT_W'(1) && recovery_clk <= CNT_OUT_W'(CNT_CEIL)));

endmodule

// File: tb/tb_pio_cycle_calc.sv
module tb_pio_cycle_calc;
    localparam int TIME_W = 12;
    localparam int PER_W  = 8;
    localparam int REV_W  = 2;

    typedef struct packed {
        logic [11:0] s_ns;
        logic [11:0] a_ns;
        logic [11:0] c_ns;
        logic [7:0]  per;
        logic [1:0]  rv;
        logic [11:0] e_s;
        logic [4:0]  e_a;
        logic [4:0]  e_r;
        logic [7:0]  e_b;
    } vec_t;

    // expected values worked out by hand from R1..R7
    localparam int NV = 10;
    localparam vec_t TABLE [NV] = '{
        '{12'd70,  12'd165, 12'd600,  8'd30, 2'd1, 12'd3, 5'd6,  5'd13, 8'h6D}, // R1 R2 plain
        '{12'd70,  12'd165, 12'd600,  8'd30, 2'd2, 12'd3, 5'd6,  5'd12, 8'h6C}, // R6 decrement
        '{12'd25,  12'd70,  12'd120,  8'd30, 2'd2, 12'd1, 5'd3,  5'd1,  8'h31}, // R4 floor then R6
        '{12'd10,  12'd20,  12'd90,   8'd30, 2'd1, 12'd1, 5'd2,  5'd2,  8'h22}, // R3 active floor
        '{12'd30,  12'd90,  12'd900,  8'd30, 2'd1, 12'd1, 5'd12, 5'd16, 8'hC0}, // R4 spill, R7 16->0
        '{12'd30,  12'd300, 12'd1200, 8'd20, 2'd2, 12'd2, 5'd16, 5'd16, 8'h00}, // R5 active ceiling
        '{12'd100, 12'd100, 12'd150,  8'd50, 2'd1, 12'd2, 5'd2,  5'd2,  8'h22}, // R2 negative recovery
        '{12'd5,   12'd18,  12'd40,   8'd1,  2'd3, 12'd5, 5'd16, 5'd16, 8'h00}, // R4 exactly 17, R5
        '{12'd5,   12'd5,   12'd28,   8'd1,  2'd1, 12'd5, 5'd6,  5'd16, 8'h60}, // R4 spill of one
        '{12'd60,  12'd120, 12'd300,  8'd30, 2'd0, 12'd2, 5'd4,  5'd4,  8'h44}  // R1 exact division
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [TIME_W-1:0] setup_ns = '0, active_ns = '0, cycle_ns = '0;
    logic [PER_W-1:0]  period_ns = '0;
    logic [REV_W-1:0]  rev = '0;
    logic              busy, done, err;
    logic [TIME_W-1:0] setup_clk;
    logic [4:0]        active_clk, recovery_clk;
    logic [7:0]        timing_byte;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    pio_cycle_calc #(.TIME_W(TIME_W), .PER_W(PER_W), .REV_W(REV_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .setup_ns(setup_ns), .active_ns(active_ns), .cycle_ns(cycle_ns),
        .period_ns(period_ns), .rev(rev),
        .busy(busy), .done(done), .err(err),
        .setup_clk(setup_clk), .active_clk(active_clk),
        .recovery_clk(recovery_clk), .timing_byte(timing_byte)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic launch(input int s, input int a, input int c, input int p, input int r);
        @(negedge clk);
        setup_ns  = TIME_W'(s);
        active_ns = TIME_W'(a);
        cycle_ns  = TIME_W'(c);
        period_ns = PER_W'(p);
        rev       = REV_W'(r);
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int k = 0; k < 2000; k++) begin
            if (done) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        bit seen;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 busy", int'(busy), 0);
        check("R11 done", int'(done), 0);
        check("R11 err", int'(err), 0);
        check("R11 byte", int'(timing_byte), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 setup_clk", int'(setup_clk), 0);

        for (int i = 0; i < NV; i++) begin
            launch(TABLE[i].s_ns, TABLE[i].a_ns, TABLE[i].c_ns, TABLE[i].per, TABLE[i].rv);
            wait_done(seen);
            check($sformatf("R8 vec%0d done", i), int'(seen), 1);
            check($sformatf("R1 vec%0d setup", i), int'(setup_clk), int'(TABLE[i].e_s));
            check($sformatf("R5 vec%0d active", i), int'(active_clk), int'(TABLE[i].e_a));
            check($sformatf("R6 vec%0d recovery", i), int'(recovery_clk), int'(TABLE[i].e_r));
            check($sformatf("R7 vec%0d byte", i), int'(timing_byte), int'(TABLE[i].e_b));
            check($sformatf("R10 vec%0d err", i), int'(err), 0);
            @(negedge clk);
            // R8: single-cycle pulse
            check($sformatf("R8 vec%0d pulse", i), int'(done), 0);
        end

        // R8: results held after done
        repeat (5) @(negedge clk);
        check("R8 held byte", int'(timing_byte), 8'h44);
        check("R8 held setup", int'(setup_clk), 2);

        // R9: second start while busy is ignored
        launch(70, 165, 600, 30, 1);
        repeat (5) @(negedge clk);
        setup_ns = 12'd30; active_ns = 12'd300; cycle_ns = 12'd1200;
        period_ns = 8'd20; rev = 2'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(seen);
        check("R9 done", int'(seen), 1);
        check("R9 byte", int'(timing_byte), 8'h6D);
        check("R9 setup", int'(setup_clk), 3);
        @(negedge clk);
        seen = 1'b0;
        for (int k = 0; k < 200; k++) begin
            if (done) seen = 1'b1;
            @(negedge clk);
        end
        check("R9 no extra done", int'(seen), 0);

        // R10: zero period gives an error result one cycle after start
        @(negedge clk);
        setup_ns = 12'd70; active_ns = 12'd165; cycle_ns = 12'd600;
        period_ns = 8'd0; rev = 2'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10 done", int'(done), 1);
        check("R10 err", int'(err), 1);
        check("R10 byte", int'(timing_byte), 0);
        check("R10 active", int'(active_clk), 0);
        check("R10 recovery", int'(recovery_clk), 0);
        check("R10 setup", int'(setup_clk), 0);

        // R10: next good request clears err
        launch(10, 20, 90, 30, 1);
        wait_done(seen);
        check("R10 err cleared", int'(err), 0);
        check("R3 after err", int'(timing_byte), 8'h22);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule